// File: doc/BRIEF.md
# Byte stream packet framer and deframer

This block converts between packet beats and a flat stuffed byte stream, one converter per direction. On the transmit side it takes beats (one data byte with start and end flags) and produces a byte stream. Each packet opens with a start marker and a channel marker with channel number zero. An end marker goes just ahead of the final data byte. Any data byte that collides with a reserved value is escaped. On the receive side it parses such a byte stream back into data beats with start and end flags.

The four reserved values are 0x7A (start), 0x7B (end), 0x7C (channel marker, always followed by one raw channel-number byte) and 0x7D (escape). An escaped byte travels as 0x7D followed by the value XOR 0x20. Only channel zero is delivered. The receiver flags protocol violations with a one-cycle error pulse and then resynchronises on the next start marker. Both sides of both converters use valid/ready handshakes.

Top module: `pkt_stream_codec`

## Requirements
- R1: Every transmitted packet begins with the three bytes 0x7A, 0x7C, 0x00, emitted before any byte derived from its first beat's data.
- R2: A data byte equal to 0x7A, 0x7B, 0x7C or 0x7D is sent as 0x7D followed by the byte XOR 0x20. The receiver drops 0x7D and XORs the next byte with 0x20. No other byte is altered.
- R3: On transmit, 0x7B is placed immediately before the encoding of the beat flagged as last, and that byte is still escaped when needed. A one-beat packet with byte b is sent as 0x7A, 0x7C, 0x00, 0x7B, then b (escaped if reserved).
- R4: The receiver discards every byte that arrives while it is not inside a packet, until a 0x7A arrives.
- R5: The receiver emits one beat per data byte. The first beat of a packet carries the start flag. The byte following 0x7B (after any escape) is emitted as the final beat with the end flag.
- R6: A received packet whose channel-number byte is nonzero produces no beats and no error pulse. The receiver then waits for the next 0x7A.
- R7: A 0x7A received inside a packet raises the error output. Beats already delivered for that packet are left without an end flag. Nothing more is delivered until a later 0x7A.
- R8: A 0x7A, 0x7B or 0x7C received where the final byte after 0x7B is expected raises the error output. The packet ends without an end-flagged beat.
- R9: While an output's valid is high and its ready is low, that output keeps valid high and holds its data and flags unchanged.
- R10: The error output is high for exactly one cycle per detected violation.
- R11: After reset both outputs are not valid, the error output is low and both inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Transmit beat valid |
| tx_in_ready | output | 1 | Transmit beat accepted |
| tx_in_data | input | 8 | Transmit beat data byte |
| tx_in_sop | input | 1 | Beat is first of packet |
| tx_in_eop | input | 1 | Beat is last of packet |
| tx_out_valid | output | 1 | Stuffed byte valid |
| tx_out_ready | input | 1 | Stuffed byte accepted downstream |
| tx_out_byte | output | 8 | Stuffed byte |
| rx_in_valid | input | 1 | Received stuffed byte valid |
| rx_in_ready | output | 1 | Received byte accepted |
| rx_in_byte | input | 8 | Received stuffed byte |
| rx_out_valid | output | 1 | Decoded beat valid |
| rx_out_ready | input | 1 | Decoded beat accepted downstream |
| rx_out_data | output | 8 | Decoded data byte |
| rx_out_sop | output | 1 | Decoded beat is first of packet |
| rx_out_eop | output | 1 | Decoded beat is last of packet |
| rx_err | output | 1 | One-cycle protocol error pulse |

## Verification
The assertions watch several properties on every cycle. They hold both outputs stable under backpressure, and they keep reserved values on the transmit side to marker and escape slots. They check that the byte after an escape is never reserved, and that the error pulse is single and lands the parser in its hunting state. They also check that decoded beats form well-nested packets, where a start only follows a closed packet and a continuation only follows an open one. The exact byte sequences need the bench's directed scenarios: header layout, end-marker placement, the escaped final byte, silent discard of foreign-channel packets and of leading garbage, and the precise beats delivered around an aborted packet.

// File: rtl/pkt_codec_pkg.sv
package pkt_codec_pkg;
  localparam int BW = 8;
  typedef logic [BW-1:0] byte_t;

  localparam byte_t K_SOP  = 8'h7A;
  localparam byte_t K_EOP  = 8'h7B;
  localparam byte_t K_CHN  = 8'h7C;
  localparam byte_t K_ESC  = 8'h7D;
  localparam byte_t K_FLIP = 8'h20;
  localparam byte_t K_CH0  = 8'h00;

  typedef enum logic [2:0] {
    FS_IDLE, FS_SOP, FS_CHM, FS_CHN, FS_EOP, FS_ESC, FS_DAT
  } fr_step_e;

  typedef enum logic [1:0] {DS_HUNT, DS_BODY, DS_CHAN, DS_LAST} df_state_e;

  function automatic logic is_reserved(byte_t b);
    return (b == K_SOP) || (b == K_EOP) || (b == K_CHN) || (b == K_ESC);
  endfunction

  function automatic byte_t flip(byte_t b);
    return b ^ K_FLIP;
  endfunction

  // step after the header (or for a non-first beat): end marker, escape or data
  function automatic fr_step_e fr_body(logic last, byte_t b);
    if (last) return FS_EOP;
    if (is_reserved(b)) return FS_ESC;
    return FS_DAT;
  endfunction

  function automatic fr_step_e fr_first(logic first, logic last, byte_t b);
    return first ? FS_SOP : fr_body(last, b);
  endfunction

  function automatic fr_step_e fr_next(fr_step_e s, logic last, byte_t b);
    case (s)
      FS_SOP:  return FS_CHM;
      FS_CHM:  return FS_CHN;
      FS_CHN:  return fr_body(last, b);
      FS_EOP:  return is_reserved(b) ? FS_ESC : FS_DAT;
      FS_ESC:  return FS_DAT;
      default: return FS_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_codec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  byte_t in_data,
  input  logic  in_sop,
  input  logic  in_eop,
  output logic  out_valid,
  input  logic  out_ready,
  output byte_t out_byte,
  output logic  marker_slot,
  output logic  esc_slot
);
  fr_step_e st;
  byte_t    held;
  logic     held_last;

  assign out_valid   = (st != FS_IDLE);
  assign in_ready    = (st == FS_IDLE) || ((st == FS_DAT) && out_ready);
  assign marker_slot = (st == FS_SOP) || (st == FS_CHM) || (st == FS_EOP) || (st == FS_ESC);
  assign esc_slot    = (st == FS_ESC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      held      <= '0;
      held_last <= 1'b0;
    end else if (in_valid && in_ready) begin
      st        <= fr_first(in_sop, in_eop, in_data);
      held      <= in_data;
      held_last <= in_eop;
    end else if (out_valid && out_ready) begin
      st <= fr_next(st, held_last, held);
    end
  end

  always_comb begin
    case (st)
      FS_SOP:  out_byte = K_SOP;
      FS_CHM:  out_byte = K_CHN;
      FS_CHN:  out_byte = K_CH0;
      FS_EOP:  out_byte = K_EOP;
      FS_ESC:  out_byte = K_ESC;
      FS_DAT:  out_byte = is_reserved(held) ? flip(held) : held;
      default: out_byte = '0;
    endcase
  end
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_codec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  byte_t in_byte,
  output logic  out_valid,
  input  logic  out_ready,
  output byte_t out_data,
  output logic  out_sop,
  output logic  out_eop,
  output logic  err,
  output logic  hunting
);
  df_state_e st, st_n;
  logic      esc, esc_n;
  logic      first, first_n;
  logic      fire, f_eop, err_n;
  byte_t     f_data;
  logic      take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign hunting  = (st == DS_HUNT);

  always_comb begin
    st_n    = st;
    esc_n   = esc;
    first_n = first;
    fire    = 1'b0;
    f_eop   = 1'b0;
    f_data  = in_byte;
    err_n   = 1'b0;
    if (take) begin
      case (st)
        DS_HUNT: begin
          if (in_byte == K_SOP) begin
            st_n    = DS_BODY;
            first_n = 1'b1;
            esc_n   = 1'b0;
          end
        end
        DS_BODY: begin
          if (esc) begin
            fire   = 1'b1;
            f_data = flip(in_byte);
            esc_n  = 1'b0;
          end else if (in_byte == K_SOP) begin
            err_n = 1'b1;
            st_n  = DS_HUNT;
          end else if (in_byte == K_EOP) begin
            st_n = DS_LAST;
          end else if (in_byte == K_CHN) begin
            st_n = DS_CHAN;
          end else if (in_byte == K_ESC) begin
            esc_n = 1'b1;
          end else begin
            fire = 1'b1;
          end
        end
        DS_CHAN: begin
          st_n = (in_byte == K_CH0) ? DS_BODY : DS_HUNT;
        end
        default: begin // DS_LAST
          if (esc) begin
            fire   = 1'b1;
            f_eop  = 1'b1;
            f_data = flip(in_byte);
            esc_n  = 1'b0;
            st_n   = DS_HUNT;
          end else if (in_byte == K_ESC) begin
            esc_n = 1'b1;
          end else if (is_reserved(in_byte)) begin
            err_n = 1'b1;
            st_n  = DS_HUNT;
          end else begin
            fire  = 1'b1;
            f_eop = 1'b1;
            st_n  = DS_HUNT;
          end
        end
      endcase
      if (fire) first_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= DS_HUNT;
      esc       <= 1'b0;
      first     <= 1'b0;
      err       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else begin
      st    <= st_n;
      esc   <= esc_n;
      first <= first_n;
      err   <= err_n;
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= f_data;
        out_sop   <= first;
        out_eop   <= f_eop;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_stream_codec.sv
module pkt_stream_codec
  import pkt_codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_in_valid,
  output logic       tx_in_ready,
  input  logic [7:0] tx_in_data,
  input  logic       tx_in_sop,
  input  logic       tx_in_eop,
  output logic       tx_out_valid,
  input  logic       tx_out_ready,
  output logic [7:0] tx_out_byte,
  input  logic       rx_in_valid,
  output logic       rx_in_ready,
  input  logic [7:0] rx_in_byte,
  output logic       rx_out_valid,
  input  logic       rx_out_ready,
  output logic [7:0] rx_out_data,
  output logic       rx_out_sop,
  output logic       rx_out_eop,
  output logic       rx_err
);
  logic fr_marker_slot;
  logic fr_esc_slot;
  logic df_hunt;

  pkt_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (tx_in_valid),
    .in_ready    (tx_in_ready),
    .in_data     (tx_in_data),
    .in_sop      (tx_in_sop),
    .in_eop      (tx_in_eop),
    .out_valid   (tx_out_valid),
    .out_ready   (tx_out_ready),
    .out_byte    (tx_out_byte),
    .marker_slot (fr_marker_slot),
    .esc_slot    (fr_esc_slot)
  );

  pkt_deframer u_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_byte   (rx_in_byte),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data),
    .out_sop   (rx_out_sop),
    .out_eop   (rx_out_eop),
    .err       (rx_err),
    .hunting   (df_hunt)
  );
endmodule

// File: rtl/pkt_codec_chk.sv
module pkt_codec_chk
  import pkt_codec_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_out_valid,
  input logic       tx_out_ready,
  input logic [7:0] tx_out_byte,
  input logic       rx_out_valid,
  input logic       rx_out_ready,
  input logic [7:0] rx_out_data,
  input logic       rx_out_sop,
  input logic       rx_out_eop,
  input logic       rx_err,
  input logic       fr_marker_slot,
  input logic       fr_esc_slot,
  input logic       df_hunt
);
  logic in_pkt;
  logic rx_beat;
  assign rx_beat = rx_out_valid && rx_out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (rx_err) in_pkt <= 1'b0;
    else if (rx_beat) in_pkt <= !rx_out_eop;
  end

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_byte));

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid &&
      $stable({rx_out_data, rx_out_sop, rx_out_eop}));

  p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err);

  p_err_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> df_hunt);

  p_reserved_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && is_reserved(tx_out_byte) |-> fr_marker_slot);

  p_after_escape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && tx_out_ready && fr_esc_slot |=>
      tx_out_valid && !is_reserved(tx_out_byte));

  p_start_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_beat && rx_out_sop |-> !in_pkt);

  p_cont_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_beat && !rx_out_sop |-> in_pkt);
endmodule

bind pkt_stream_codec pkt_codec_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_out_valid   (tx_out_valid),
  .tx_out_ready   (tx_out_ready),
  .tx_out_byte    (tx_out_byte),
  .rx_out_valid   (rx_out_valid),
  .rx_out_ready   (rx_out_ready),
  .rx_out_data    (rx_out_data),
  .rx_out_sop     (rx_out_sop),
  .rx_out_eop     (rx_out_eop),
  .rx_err         (rx_err),
  .fr_marker_slot (fr_marker_slot),
  .fr_esc_slot    (fr_esc_slot),
  .df_hunt        (df_hunt)
);

// File: tb/tb_pkt_stream_codec.sv
`timescale 1ns/1ps
module tb_pkt_stream_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_in_valid = 1'b0, tx_in_sop = 1'b0, tx_in_eop = 1'b0;
  logic [7:0] tx_in_data = 8'h00;
  logic       tx_in_ready, tx_out_valid;
  logic       tx_out_ready = 1'b1;
  logic [7:0] tx_out_byte;
  logic       rx_in_valid = 1'b0;
  logic [7:0] rx_in_byte = 8'h00;
  logic       rx_in_ready, rx_out_valid, rx_out_sop, rx_out_eop, rx_err;
  logic       rx_out_ready = 1'b1;
  logic [7:0] rx_out_data;

  always #2 clk = ~clk;

  pkt_stream_codec dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit bp = 1'b0, done = 1'b0;
  logic [7:0] tx_seen[$];
  logic [7:0] rx_d[$];
  bit rx_s[$], rx_e[$];
  int err_pulses = 0, err_run = 0, err_run_max = 0;
  int stall_seen = 0, stall_bad = 0;
  bit tx_st = 0, rx_st = 0;
  logic [7:0] tx_prev = 0;
  logic [10:0] rx_prev = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // backpressure pattern driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    tx_out_ready <= bp ? (cyc % 3 != 0) : 1'b1;
    rx_out_ready <= bp ? (cyc % 4 >= 2) : 1'b1;
  end

  // monitors sample just before the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (tx_st) begin
        stall_seen++;
        if (!tx_out_valid || tx_out_byte != tx_prev) stall_bad++;
      end
      if (rx_st) begin
        stall_seen++;
        if (!rx_out_valid || {rx_out_data, rx_out_sop, rx_out_eop} != rx_prev) stall_bad++;
      end
      tx_st = tx_out_valid && !tx_out_ready;
      tx_prev = tx_out_byte;
      rx_st = rx_out_valid && !rx_out_ready;
      rx_prev = {rx_out_data, rx_out_sop, rx_out_eop};
      if (tx_out_valid && tx_out_ready) tx_seen.push_back(tx_out_byte);
      if (rx_out_valid && rx_out_ready) begin
        rx_d.push_back(rx_out_data);
        rx_s.push_back(rx_out_sop);
        rx_e.push_back(rx_out_eop);
      end
      if (rx_err) begin
        if (err_run == 0) err_pulses++;
        err_run++;
        if (err_run > err_run_max) err_run_max = err_run;
      end else err_run = 0;
    end
  end

  function automatic bit special(logic [7:0] b);
    return (b >= 8'h7A) && (b <= 8'h7D);
  endfunction

  // expected stuffed stream, built from the requirements
  function automatic void frame_of(input logic [7:0] p[$], ref logic [7:0] q[$]);
    q.push_back(8'h7A); q.push_back(8'h7C); q.push_back(8'h00);
    foreach (p[i]) begin
      if (i == p.size() - 1) q.push_back(8'h7B);
      if (special(p[i])) begin
        q.push_back(8'h7D); q.push_back(p[i] ^ 8'h20);
      end else q.push_back(p[i]);
    end
  endfunction

  task automatic tx_packet(input logic [7:0] p[$]);
    for (int i = 0; i < p.size(); i++) begin
      @(negedge clk);
      tx_in_valid = 1'b1; tx_in_data = p[i];
      tx_in_sop = (i == 0); tx_in_eop = (i == p.size() - 1);
      #1;
      while (!tx_in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    tx_in_valid = 1'b0; tx_in_sop = 1'b0; tx_in_eop = 1'b0;
  endtask

  task automatic rx_stream(input logic [7:0] s[$]);
    for (int i = 0; i < s.size(); i++) begin
      @(negedge clk);
      rx_in_valid = 1'b1; rx_in_byte = s[i];
      #1;
      while (!rx_in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic cmp_tx(input string req, input logic [7:0] exp[$]);
    check(tx_seen.size() == exp.size(), req, "tx length", tx_seen.size(), exp.size());
    for (int i = 0; i < exp.size() && i < tx_seen.size(); i++)
      check(tx_seen[i] == exp[i], req, $sformatf("tx byte %0d", i), tx_seen[i], exp[i]);
    tx_seen.delete();
  endtask

  task automatic cmp_rx(input string req, input logic [7:0] d[$], input bit s[$], input bit e[$]);
    check(rx_d.size() == d.size(), req, "rx beat count", rx_d.size(), d.size());
    for (int i = 0; i < d.size() && i < rx_d.size(); i++)
      check({rx_d[i], rx_s[i], rx_e[i]} == {d[i], s[i], e[i]}, req,
            $sformatf("rx beat %0d {data,sop,eop}", i),
            {rx_d[i], rx_s[i], rx_e[i]}, {d[i], s[i], e[i]});
    rx_d.delete(); rx_s.delete(); rx_e.delete();
  endtask

  task automatic t_reset();
    #1;
    check(!tx_out_valid && !rx_out_valid, "R11", "outputs valid", {tx_out_valid, rx_out_valid}, 0);
    check(!rx_err, "R11", "err", rx_err, 0);
    check(tx_in_ready && rx_in_ready, "R11", "inputs ready", {tx_in_ready, rx_in_ready}, 3);
  endtask

  task automatic t_tx_plain();  // R1 header, R3 end marker placement
    logic [7:0] e[$];
    frame_of('{8'h11, 8'h22, 8'h33, 8'h44}, e);
    tx_packet('{8'h11, 8'h22, 8'h33, 8'h44});
    settle();
    cmp_tx("R1", e);
  endtask

  task automatic t_tx_escape();  // R2 escaping, R3 escaped final byte
    logic [7:0] e[$];
    frame_of('{8'h7A, 8'h05, 8'h7D, 8'h7C, 8'h7B}, e);
    tx_packet('{8'h7A, 8'h05, 8'h7D, 8'h7C, 8'h7B});
    settle();
    cmp_tx("R2", e);
  endtask

  task automatic t_tx_single();  // R3 one-beat packet
    tx_packet('{8'h7D});
    settle();
    cmp_tx("R3", '{8'h7A, 8'h7C, 8'h00, 8'h7B, 8'h7D, 8'h5D});
  endtask

  task automatic t_tx_backpressure();  // R9
    logic [7:0] e[$];
    frame_of('{8'h7A, 8'h01, 8'h02}, e);
    frame_of('{8'h03}, e);
    bp = 1'b1; stall_seen = 0; stall_bad = 0;
    tx_packet('{8'h7A, 8'h01, 8'h02});
    tx_packet('{8'h03});
    settle();
    bp = 1'b0;
    cmp_tx("R9", e);
    check(stall_seen > 0 && stall_bad == 0, "R9", "tx held under stall", stall_bad, 0);
  endtask

  task automatic t_rx_garbage_escape();  // R4 discard, R5 flags, R2 unescape
    logic [7:0] s[$];
    s = '{8'h11, 8'h7B, 8'h7D, 8'h22};
    frame_of('{8'h7D, 8'h01, 8'h7C, 8'h7B}, s);
    rx_stream(s);
    settle();
    cmp_rx("R4", '{8'h7D, 8'h01, 8'h7C, 8'h7B}, '{1, 0, 0, 0}, '{0, 0, 0, 1});
    check(err_pulses == 0, "R5", "no error", err_pulses, 0);
  endtask

  task automatic t_rx_channel();  // R6
    rx_stream('{8'h7A, 8'h7C, 8'h05, 8'h11, 8'h7B, 8'h22,
                8'h7A, 8'h7C, 8'h00, 8'h33, 8'h7B, 8'h44});
    settle();
    cmp_rx("R6", '{8'h33, 8'h44}, '{1, 0}, '{0, 1});
    check(err_pulses == 0, "R6", "no error on foreign channel", err_pulses, 0);
  endtask

  task automatic t_rx_double_sop();  // R7
    rx_stream('{8'h7A, 8'h7C, 8'h00, 8'h11, 8'h22, 8'h7A, 8'h33, 8'h7B, 8'h44,
                8'h7A, 8'h7C, 8'h00, 8'h7B, 8'h66});
    settle();
    cmp_rx("R7", '{8'h11, 8'h22, 8'h66}, '{1, 0, 1}, '{0, 0, 1});
    check(err_pulses == 1, "R7", "error pulses", err_pulses, 1);
  endtask

  task automatic t_rx_bad_last();  // R8, R10
    rx_stream('{8'h7A, 8'h7C, 8'h00, 8'h55, 8'h7B, 8'h7C,
                8'h7A, 8'h7C, 8'h00, 8'h7B, 8'h7D, 8'h5A});
    settle();
    cmp_rx("R8", '{8'h55, 8'h7A}, '{1, 1}, '{0, 1});
    check(err_pulses == 2, "R8", "error pulses total", err_pulses, 2);
    check(err_run_max == 1, "R10", "longest error run", err_run_max, 1);
  endtask

  task automatic t_rx_backpressure();  // R9
    logic [7:0] s[$];
    frame_of('{8'h4A, 8'h7A, 8'h10}, s);
    frame_of('{8'h7B}, s);
    bp = 1'b1; stall_seen = 0; stall_bad = 0;
    rx_stream(s);
    settle();
    bp = 1'b0;
    cmp_rx("R9", '{8'h4A, 8'h7A, 8'h10, 8'h7B}, '{1, 0, 0, 1}, '{0, 0, 1, 1});
    check(stall_seen > 0 && stall_bad == 0, "R9", "rx held under stall", stall_bad, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_plain();
    t_tx_escape();
    t_tx_single();
    t_tx_backpressure();
    t_rx_garbage_escape();
    t_rx_channel();
    t_rx_double_sop();
    t_rx_bad_last();
    t_rx_backpressure();
    finish_run();
  end
endmodule